// File: doc/BRIEF.md
# Center-Aligned Complementary PWM Timer

The block is a symmetric-triangle PWM generator. A 16-bit counter climbs from zero to a programmed period value and then walks back down to zero, so one PWM cycle lasts twice the period value in clock cycles. Three duty channels compare the count against their own compare value. Each one drives a complementary pair of outputs: a positive phase and a negative phase that is always its opposite. Two further compare channels only raise single-cycle interrupt pulses. The block also pulses a flag at the top of the triangle and another at the bottom.

Software writes new period and compare values through plain write-enable ports into buffer registers. A buffer reaches its active register only when the count is zero, so a new duty never lands in the middle of a cycle. A duty value equal to or above the period keeps the positive phase low and the negative phase high for as many whole cycles as the value is held. One polarity input inverts every output pair and changes no timing. An enable input parks the counter at zero and returns every pair to its idle state.

Top module: `cpwm_timer`

## Requirements
- R1: While `en` is high, `count` steps by one on every clock: 0, 1, ..., P, P-1, ..., 1, 0, 1, ... where P is the active period (P >= 1). One cycle lasts 2P clocks.
- R2: For a duty channel i whose active compare C satisfies 0 < C < P, the internal state sets on the clock edge where `count` equals C on the rising slope and clears on the edge where `count` equals C on the falling slope. At the peak (count = P) and the valley (count = 0) the channel counts as falling. With `active_low` = 0, `pwm_pos[i]` equals that state and `pwm_neg[i]` its complement, so the positive phase is high for 2(P-C) clocks per cycle.
- R3: A duty compare of C >= P never sets the channel. A compare equal to P matches only as falling. `pwm_pos[i]` stays at its inactive level and `pwm_neg[i]` at its active level for every cycle that uses such a value.
- R4: A duty compare of 0 produces no set event, and the positive phase stays inactive for the whole cycle.
- R5: `cmp_irq[i]` (i = 0..4) is high for exactly one clock following each clock edge at which `en` is high and `count` equals channel i's active compare. Channels 3 and 4 drive no pins.
- R6: `peak_irq` is high for one clock following each enabled edge at which `count` equals P. `valley_irq` is high for one clock following each enabled edge at which `count` equals 0.
- R7: Writing `wdata` with `cmp_we[i]` (or `per_we`) high loads buffer i (or the period buffer) at that edge. Buffers copy into the active registers only at an edge where `count` is 0. A write made mid-cycle has no effect on the outputs or interrupts until the next valley.
- R8: At an edge where `en` is low, `count` goes to 0, every duty channel clears, and no interrupt fires. All pairs rest at their idle levels: positive inactive, negative active. While `count` is held at 0, the buffers load continuously.
- R9: `active_low` = 1 inverts both phases of every pair combinationally: `pwm_pos[i]` = state XOR `active_low` and `pwm_neg[i]` = NOT state XOR `active_low`. Counting and interrupts are unchanged.
- R10: After reset, `count` is 0, every `pwm_pos` is 0, every `pwm_neg` is 1 (with `active_low` = 0), and all interrupt outputs are 0. The period and all compares reset to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low parks the counter at zero |
| active_low | input | 1 | Inverts every output pair |
| wdata | input | 16 | Write data shared by all buffers |
| per_we | input | 1 | Write enable for the period buffer |
| cmp_we | input | 5 | Write enable per compare buffer; bit i selects channel i |
| count | output | 16 | Current counter value |
| pwm_pos | output | 3 | Positive phase of duty channels 0..2 |
| pwm_neg | output | 3 | Negative phase of duty channels 0..2 |
| cmp_irq | output | 5 | One-clock match pulse per compare channel |
| peak_irq | output | 1 | One-clock pulse after the count reaches the period |
| valley_irq | output | 1 | One-clock pulse after the count is zero while enabled |

## Verification
`count` takes its new value at the same edge that samples `en`. The duty state, each compare pulse and the peak and valley flags are all registered from the count value present before an edge, so each becomes visible one clock after the count value that causes it. The bench steps one edge at a time and samples one nanosecond after the edge. It predicts each output from the triangle phase of the previous edge and from a model of the active registers. That model copies the buffers only after checking an edge whose prior count was zero, so a mid-cycle write must not show until the next valley. The polarity input acts without a clock, so it is changed only between steps and read back in the same sample.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;
  // slope of the triangle the counter is currently tracing
  typedef enum logic {
    SLOPE_UP   = 1'b0,
    SLOPE_DOWN = 1'b1
  } slope_e;
endpackage

// File: rtl/cpwm_counter.sv
module cpwm_counter
  import cpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] per_act,
  input  logic             at_peak,
  output logic [CNT_W-1:0] count,
  output logic             rising,
  output logic             at_valley,
  output logic             peak_irq,
  output logic             valley_irq
);

  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  slope_e           dir_q, dir_d;
  logic             peak_q, peak_d;
  logic             vly_q, vly_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);

  // next-state: triangle walk
  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    if (!en) begin
      cnt_d = '0;
      dir_d = SLOPE_UP;
    end else if (dir_q == SLOPE_UP) begin
      if (cnt_q >= per_act) begin
        dir_d = SLOPE_DOWN;
        cnt_d = at_zero ? '0 : cnt_q - ONE;
      end else begin
        cnt_d = cnt_q + ONE;
      end
    end else begin
      if (at_zero) begin
        dir_d = SLOPE_UP;
        cnt_d = (per_act == '0) ? '0 : ONE;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
    peak_d = en && at_peak;
    vly_d  = en && at_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      dir_q  <= SLOPE_UP;
      peak_q <= 1'b0;
      vly_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      dir_q  <= dir_d;
      peak_q <= peak_d;
      vly_q  <= vly_d;
    end
  end

  // peak and valley both belong to the falling half
  assign rising     = en && (dir_q == SLOPE_UP) && !at_peak && !at_zero;
  assign at_valley  = at_zero;
  assign count      = cnt_q;
  assign peak_irq   = peak_q;
  assign valley_irq = vly_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (cnt_q <= per_act)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (!en || (cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)
            || ((cnt_q == '0) && ($past(cnt_q) == '0)))); // R1

  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)); // R8

  AST_PEAK_VALLEY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(per_act) != '0) |-> !(peak_q && vly_q)); // R6

endmodule

// File: rtl/cpwm_slot.sv
module cpwm_slot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CNT_W-1:0] wdata,
  input  logic             load,
  input  logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] act,
  output logic             hit
);

  logic [CNT_W-1:0] buf_q, buf_d;
  logic [CNT_W-1:0] act_q, act_d;

  always_comb begin
    buf_d = we   ? wdata : buf_q;
    act_d = load ? buf_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      act_q <= '0;
    end else begin
      buf_q <= buf_d;
      act_q <= act_d;
    end
  end

  assign act = act_q;
  assign hit = (count == act_q);

  AST_LOAD_AT_VALLEY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != $past(act_q)) |-> ($past(count) == '0)); // R7

endmodule

// File: rtl/cpwm_duty_ff.sv
module cpwm_duty_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic hit,
  input  logic rising,
  input  logic active_low,
  output logic pos,
  output logic neg
);

  logic ff_q, ff_d;

  always_comb begin
    ff_d = ff_q;
    if (!en) begin
      ff_d = 1'b0;
    end else if (hit && rising) begin
      ff_d = 1'b1;
    end else if (hit) begin
      ff_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else begin
      ff_q <= ff_d;
    end
  end

  assign pos = ff_q ^ active_low;
  assign neg = (!ff_q) ^ active_low;

  AST_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ((pos == active_low) && (neg != active_low))); // R8

endmodule

// File: rtl/cpwm_timer.sv
module cpwm_timer #(
  parameter int CNT_W  = 16,
  parameter int N_DUTY = 3,
  parameter int N_IRQ  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              active_low,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              per_we,
  input  logic [N_DUTY+N_IRQ-1:0] cmp_we,
  output logic [CNT_W-1:0]  count,
  output logic [N_DUTY-1:0] pwm_pos,
  output logic [N_DUTY-1:0] pwm_neg,
  output logic [N_DUTY+N_IRQ-1:0] cmp_irq,
  output logic              peak_irq,
  output logic              valley_irq
);

  localparam int N_CH = N_DUTY + N_IRQ;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] per_act;
  logic             at_peak;
  logic             at_valley;
  logic             rising;
  logic [CNT_W-1:0] cmp_act [N_CH];
  logic [N_CH-1:0]  hit;
  logic [N_CH-1:0]  irq_q, irq_d;

  cpwm_slot #(.CNT_W(CNT_W)) u_per (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (per_we),
    .wdata (wdata),
    .load  (at_valley),
    .count (cnt),
    .act   (per_act),
    .hit   (at_peak)
  );

  cpwm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .en         (en),
    .per_act    (per_act),
    .at_peak    (at_peak),
    .count      (cnt),
    .rising     (rising),
    .at_valley  (at_valley),
    .peak_irq   (peak_irq),
    .valley_irq (valley_irq)
  );

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    cpwm_slot #(.CNT_W(CNT_W)) u_slot (
      .clk   (clk),
      .rst_n (rst_int_n),
      .we    (cmp_we[g]),
      .wdata (wdata),
      .load  (at_valley),
      .count (cnt),
      .act   (cmp_act[g]),
      .hit   (hit[g])
    );

    if (g < N_DUTY) begin : g_pin
      cpwm_duty_ff u_ff (
        .clk        (clk),
        .rst_n      (rst_int_n),
        .en         (en),
        .hit        (hit[g]),
        .rising     (rising),
        .active_low (active_low),
        .pos        (pwm_pos[g]),
        .neg        (pwm_neg[g])
      );

      AST_NO_SET_HIGH_CMP: assert property (@(posedge clk) disable iff (!rst_int_n)
        (!active_low && !$past(active_low) && $rose(pwm_pos[g]))
        |-> (($past(cmp_act[g]) < $past(per_act)) && ($past(cmp_act[g]) != '0))); // R3
    end

    AST_IRQ_MATCH: assert property (@(posedge clk) disable iff (!rst_int_n)
      irq_q[g] |-> ($past(cnt) == $past(cmp_act[g]))); // R5
  end

  always_comb begin
    irq_d = en ? hit : '0;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_q <= '0;
    end else begin
      irq_q <= irq_d;
    end
  end

  assign cmp_irq = irq_q;
  assign count   = cnt;

endmodule

// File: tb/sim_cpwm_timer.sv
module sim_cpwm_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        pol = 1'b0;
  logic        per_we = 1'b0;
  logic [4:0]  cmp_we = '0;
  logic [15:0] wdata = '0;
  logic [15:0] count;
  logic [2:0]  pwm_pos, pwm_neg;
  logic [4:0]  cmp_irq;
  logic        peak_irq, valley_irq;

  cpwm_timer u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .active_low (pol),
    .wdata      (wdata),
    .per_we     (per_we),
    .cmp_we     (cmp_we),
    .count      (count),
    .pwm_pos    (pwm_pos),
    .pwm_neg    (pwm_neg),
    .cmp_irq    (cmp_irq),
    .peak_irq   (peak_irq),
    .valley_irq (valley_irq)
  );

  always #10 clk = ~clk;

  int    errors = 0;
  int    checks = 0;
  bit    done = 0;
  int    m_per_buf = 0, m_per_act = 0;
  int    m_buf [5];
  int    m_act [5];
  int    mk = 0, mcnt = 0;
  string tag_ovr = "";

  function automatic int tri_at(int k, int p);
    int t;
    t = k % (2 * p);
    return (t <= p) ? t : 2 * p - t;
  endfunction

  task automatic chk(string req, int a, int e);
    checks++;
    if (a != e) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, a, e);
    end
  endtask

  // one clock edge; wch = -1 no write, 0..4 compare, 5 period
  task automatic step(int wch, int wval);
    int    c_prev, ph, nc, c;
    bit    ff_e;
    string rq;
    per_we = (wch == 5);
    cmp_we = (wch >= 0 && wch < 5) ? 5'(1 << wch) : 5'd0;
    wdata  = 16'(wval);
    c_prev = mcnt;
    ph     = (m_per_act > 0) ? mk % (2 * m_per_act) : 0;
    @(posedge clk);
    #1;
    per_we = 1'b0;
    cmp_we = '0;
    nc = en ? tri_at(mk + 1, m_per_act) : 0;
    chk(en ? "R1" : "R8", int'(count), nc);
    for (int i = 0; i < 3; i++) begin
      c = m_act[i];
      ff_e = en && (c > 0) && (c < m_per_act) && (ph >= c) && (ph <= 2 * m_per_act - c - 1);
      if (!en) rq = "R8";
      else if (tag_ovr != "") rq = tag_ovr;
      else if (c == 0) rq = "R4";
      else if (c >= m_per_act) rq = "R3";
      else rq = "R2";
      chk(pol ? "R9" : rq, int'(pwm_pos[i]), int'(ff_e ^ pol));
      chk(pol ? "R9" : rq, int'(pwm_neg[i]), int'((!ff_e) ^ pol));
    end
    for (int i = 0; i < 5; i++) begin
      chk(en ? "R5" : "R8", int'(cmp_irq[i]), int'(en && (c_prev == m_act[i])));
    end
    chk(en ? "R6" : "R8", int'(peak_irq), int'(en && (c_prev == m_per_act)));
    chk(en ? "R6" : "R8", int'(valley_irq), int'(en && (c_prev == 0)));
    if (c_prev == 0) begin
      m_per_act = m_per_buf;
      for (int i = 0; i < 5; i++) m_act[i] = m_buf[i];
    end
    if (wch == 5) m_per_buf = wval;
    else if (wch >= 0) m_buf[wch] = wval;
    mcnt = nc;
    mk = en ? mk + 1 : 0;
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) begin
      m_buf[i] = 0;
      m_act[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", int'(count), 0);
    chk("R10", int'(pwm_pos), 0);
    chk("R10", int'(pwm_neg), 7);
    chk("R10", int'(cmp_irq), 0);
    chk("R10", int'(peak_irq), 0);
    chk("R10", int'(valley_irq), 0);

    // sweep of compare values below, at and above the period, both polarities
    for (int pi = 0; pi < 2; pi++) begin
      int pv;
      pv = (pi == 0) ? 5 : 3;
      for (int base = 0; base <= pv + 1; base++) begin
        pol = base[0];
        step(5, pv);
        for (int ch = 0; ch < 5; ch++) step(ch, (base + ch) % (pv + 2));
        step(-1, 0);
        step(-1, 0);
        en = 1'b1;
        for (int s = 0; s < 4 * pv + 1; s++) step(-1, 0);
        en = 1'b0;
        step(-1, 0);
      end
    end

    // R7 mid-cycle writes take effect at the next valley only
    pol = 1'b0;
    step(5, 4);
    step(0, 2);
    step(1, 1);
    step(2, 3);
    step(3, 4);
    step(4, 0);
    step(-1, 0);
    step(-1, 0);
    en = 1'b1;
    tag_ovr = "R7";
    for (int s = 0; s < 40; s++) begin
      if (s == 3) step(0, 1);
      else if (s == 11) step(1, 3);
      else if (s == 13) step(2, 5);
      else if (s == 20) step(3, 2);
      else if (s == 27) step(4, 4);
      else step(-1, 0);
    end
    tag_ovr = "";

    // R9 polarity flipped while running
    for (int s = 0; s < 5; s++) step(-1, 0);
    pol = 1'b1;
    for (int s = 0; s < 5; s++) step(-1, 0);
    pol = 1'b0;
    step(-1, 0);

    // R8 disable in mid-cycle
    en = 1'b0;
    step(-1, 0);
    step(-1, 0);
    en = 1'b1;
    for (int s = 0; s < 10; s++) step(-1, 0);
    en = 1'b0;
    step(-1, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule